// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a charge-redistribution successive-approximation converter. It sits between a pair of capacitor arrays, their switches and a single comparator. While idle it keeps the arrays in acquisition: the comparator-side nodes are held at ground and the array plates follow the analog inputs. A rising edge on the convert pin freezes the sample. The block then runs the switch sequence that isolates the held charge and resolves the result one bit per clock, most significant bit first.

The sequencer runs on its own conversion clock and needs no serial clock. A conversion takes a fixed 3 + NBITS clock cycles: three for the switch steps and one per bit trial. On the last trial the result is written to the code output, busy drops, and the switches go back to acquisition in the same edge, so the code always belongs to the sample just taken. The result and busy are plain level outputs. There is no handshake: the code holds its value until the next conversion finishes, and busy falling marks the new value.

Top module: `sar_seq`

## Requirements
- R1: A synchronous reset, active high on `rst`, leaves the block idle: busy low, `samp_close` and `in_connect` high, `gnd_connect` low, `bit_ctl` all zero and `code` zero. This also holds when reset arrives in the middle of a conversion.
- R2: A rising edge of `conv_start` seen while idle raises `busy` in the next cycle. Busy then stays high for exactly 3 + NBITS cycles, which is 19 for 16 bits.
- R3: The switch steps come in a fixed order, one per cycle. In the first busy cycle `samp_close` is low and `in_connect` is still high. In the second, `in_connect` is low and `gnd_connect` is still low. In the third, `gnd_connect` is high and `bit_ctl` is zero. `in_connect` and `gnd_connect` are never high together.
- R4: Whenever `busy` is low, the block is in acquisition: `samp_close`=1, `in_connect`=1, `gnd_connect`=0 and `bit_ctl`=0.
- R5: Trials run from bit NBITS-1 down to bit 0. In trial j (j=0 being the MSB trial, starting in the fourth busy cycle), `bit_ctl` holds the bits already kept above bit NBITS-1-j, has that bit set to 1 (element switched to reference), and has all lower bits at 0.
- R6: The comparator input `cmp_high` (1 = DAC level above the held input) is sampled on the clock edge that ends each trial. When it is 1, the trial bit is cleared. When it is 0, the bit is kept.
- R7: On the edge that ends the last trial, `code` takes the resolved value and `busy` falls. `code` changes on no other edge. With an ideal comparator, `code` equals the held sample.
- R8: `conv_start` edges while busy is high are ignored. A `conv_start` held high past the end of a conversion does not start another one. Only a fresh rising edge does.
- R9: A rising edge in the first idle cycle after a conversion starts a new conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Convert request; its rising edge starts a conversion |
| cmp_high | input | 1 | Comparator: 1 when the DAC level exceeds the held input |
| samp_close | output | 1 | Comparator-side sampling switches closed (nodes to ground) |
| in_connect | output | 1 | Array plates connected to the analog inputs |
| gnd_connect | output | 1 | Array plates tied to ground for the bit trials |
| bit_ctl | output | NBITS | Per-element switch control, 1 = reference, 0 = ground |
| busy | output | 1 | Conversion in progress |
| code | output | NBITS | Last conversion result |

## Verification
The bench builds the block with its default NBITS of 16. At this width every trial position of a full-width code can be seen, and the all-ones, all-zeros and single-bit corner codes can be driven in directed cases. A comparator model in the bench compares `bit_ctl` against a held sample value. This lets every trial pattern and every final code be predicted from the sample alone, over a fixed-seed random spread of samples. Convert pulses during busy, a held-high convert pin, back-to-back starts and a reset in the middle of a conversion cover the ignore and restart rules.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    PH_ACQ   = 3'd0,
    PH_OPEN  = 3'd1,
    PH_DISC  = 3'd2,
    PH_GND   = 3'd3,
    PH_TRIAL = 3'd4
  } phase_t;
endpackage

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic din,
  output logic rise
);
  logic prev_q;

  // previous level tracked through reset so a held level never looks like an edge
  always_ff @(posedge clk) prev_q <= din;

  assign rise = din & ~prev_q;
endmodule

// File: rtl/sar_phase.sv
module sar_phase
  import sar_pkg::*;
#(
  parameter int NBITS = 16,
  localparam int IDXW = $clog2(NBITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output phase_t          phase,
  output logic            first,
  output logic            decide,
  output logic            last,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] TOP = IDXW'(NBITS - 1);

  phase_t          ph_q;
  logic [IDXW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_ACQ;
      idx_q <= '0;
    end else begin
      case (ph_q)
        PH_ACQ:   if (start) ph_q <= PH_OPEN;
        PH_OPEN:  ph_q <= PH_DISC;
        PH_DISC:  ph_q <= PH_GND;
        PH_GND: begin
          ph_q  <= PH_TRIAL;
          idx_q <= TOP;
        end
        PH_TRIAL: begin
          if (idx_q == '0) ph_q <= PH_ACQ;
          else             idx_q <= idx_q - 1'b1;
        end
        default:  ph_q <= PH_ACQ;
      endcase
    end
  end

  assign phase  = ph_q;
  assign idx    = idx_q;
  assign first  = (ph_q == PH_GND);
  assign decide = (ph_q == PH_TRIAL);
  assign last   = decide && (idx_q == '0);
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int NBITS = 16,
  localparam int IDXW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             decide,
  input  logic             last,
  input  logic [IDXW-1:0]  idx,
  input  logic             cmp_high,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] code
);
  logic [NBITS-1:0] trial_q, code_q, nxt;

  // per element: resolve the active bit, arm the one below, keep the rest
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    always_comb begin
      if (idx == IDXW'(g))
        nxt[g] = trial_q[g] & ~cmp_high;
      else if (g + 1 < NBITS && idx == IDXW'(g + 1))
        nxt[g] = 1'b1;
      else
        nxt[g] = trial_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q <= '0;
      code_q  <= '0;
    end else if (first) begin
      trial_q <= {1'b1, {(NBITS-1){1'b0}}};
    end else if (decide) begin
      if (last) begin
        code_q  <= nxt;
        trial_q <= '0;
      end else begin
        trial_q <= nxt;
      end
    end
  end

  assign trial = trial_q;
  assign code  = code_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cmp_high,
  output logic             samp_close,
  output logic             in_connect,
  output logic             gnd_connect,
  output logic [NBITS-1:0] bit_ctl,
  output logic             busy,
  output logic [NBITS-1:0] code
);
  localparam int IDXW = $clog2(NBITS);

  logic            rise, first, decide, last;
  logic [IDXW-1:0] idx;
  phase_t          phase;

  sar_edge u_edge (.clk(clk), .din(conv_start), .rise(rise));

  sar_phase #(.NBITS(NBITS)) u_phase (
    .clk(clk), .rst(rst), .start(rise), .phase(phase),
    .first(first), .decide(decide), .last(last), .idx(idx)
  );

  sar_trial #(.NBITS(NBITS)) u_trial (
    .clk(clk), .rst(rst), .first(first), .decide(decide), .last(last),
    .idx(idx), .cmp_high(cmp_high), .trial(bit_ctl), .code(code)
  );

  assign busy        = (phase != PH_ACQ);
  assign samp_close  = (phase == PH_ACQ);
  assign in_connect  = (phase == PH_ACQ) || (phase == PH_OPEN);
  assign gnd_connect = (phase == PH_GND) || (phase == PH_TRIAL);
endmodule

module sar_seq_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_start,
  input logic             samp_close,
  input logic             in_connect,
  input logic             gnd_connect,
  input logic [NBITS-1:0] bit_ctl,
  input logic             busy,
  input logic [NBITS-1:0] code
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_start) && !busy) |=> busy);

  // R3
  open_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(samp_close) |-> (in_connect && !gnd_connect));

  // R3
  disc_second_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_connect) |-> (!samp_close && !gnd_connect));

  // R3
  gnd_third_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gnd_connect) |-> (!in_connect && bit_ctl == '0));

  // R3
  no_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_connect && gnd_connect));

  // R4
  idle_acq_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (samp_close && in_connect && !gnd_connect && bit_ctl == '0));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(code));
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .samp_close(samp_close),
  .in_connect(in_connect), .gnd_connect(gnd_connect), .bit_ctl(bit_ctl),
  .busy(busy), .code(code)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic         cmp_high;
  logic         samp_close, in_connect, gnd_connect, busy;
  logic [N-1:0] bit_ctl, code;
  logic [N-1:0] vin = '0;
  logic [N-1:0] last_code = '0;
  int           errors = 0;
  int           checks = 0;
  int           cycles = 0;
  bit           armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: DAC level above held sample
  assign cmp_high = (bit_ctl > vin);

  sar_seq #(.NBITS(N)) u0 (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_high(cmp_high),
    .samp_close(samp_close), .in_connect(in_connect), .gnd_connect(gnd_connect),
    .bit_ctl(bit_ctl), .busy(busy), .code(code)
  );

  function automatic logic [N-1:0] exp_trial(logic [N-1:0] v, int j);
    int b = N - 1 - j;
    logic [N:0] above = ~(({{N{1'b0}}, 1'b1} << (b + 1)) - 1'b1);
    return (v & above[N-1:0]) | (N'(1) << b);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_chk(string req);
    chk(!busy && samp_close && in_connect && !gnd_connect && bit_ctl == '0, req,
        {busy, samp_close, in_connect, gnd_connect, 12'd0, bit_ctl}, 32'h6000_0000);
  endtask

  // hold: keep conv_start high past the end; glitch: pulse during busy; chain: start again at once
  task automatic run_conv(logic [N-1:0] v, bit hold, bit glitch, bit chain);
    int  busy_n = 0;
    bit  trial_ok = 1'b1;
    logic [N-1:0] bad = '0;
    if (!armed) begin
      @(negedge clk);
      vin = v;
      conv_start = 1'b1;
    end
    armed = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (n == 1 && !hold) conv_start = 1'b0;
      if (glitch && n == 6) conv_start = 1'b1;
      if (glitch && n == 7) conv_start = 1'b0;
      if (glitch && n == 12) conv_start = 1'b1;
      if (glitch && n == 13) conv_start = 1'b0;
      if (busy) busy_n++;
      if (n == 1)
        chk(busy && !samp_close && in_connect && !gnd_connect, "R3 open step",
            {busy, samp_close, in_connect, gnd_connect}, 4'b1010);
      if (n == 2)
        chk(busy && !samp_close && !in_connect && !gnd_connect, "R3 disconnect step",
            {busy, samp_close, in_connect, gnd_connect}, 4'b1000);
      if (n == 3)
        chk(gnd_connect && !in_connect && bit_ctl == '0, "R3 ground step",
            {gnd_connect, in_connect, bit_ctl}, 18'h20000);
      if (n >= 4 && n <= 19 && bit_ctl !== exp_trial(v, n - 4)) begin
        trial_ok = 1'b0;
        bad = bit_ctl;
      end
      if (n == 10)
        chk(code == last_code, "R7 code held during conversion", code, last_code);
      if (n == 20 && chain) begin
        vin = ~v;
        conv_start = 1'b1;
        armed = 1'b1;
      end
    end
    chk(trial_ok, "R5 R6 trial patterns", bad, v);
    chk(busy_n == N + 3, "R2 busy length", busy_n, N + 3);
    chk(code == v, "R7 final code", code, v);
    if (!chain) idle_chk("R4 idle after return");
    last_code = v;
    if (glitch || hold) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R8 no retrigger", busy, 0);
      conv_start = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    idle_chk("R1 idle during reset");
    chk(code == '0, "R1 code zero", code, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_chk("R1 idle after reset");

    run_conv(16'hFFFF, 0, 0, 0);
    run_conv(16'h0000, 0, 0, 0);
    run_conv(16'h8000, 0, 0, 0);
    run_conv(16'h7FFF, 0, 0, 0);
    run_conv(16'h0001, 0, 1, 0);
    run_conv(16'hA5C3, 1, 0, 0);
    run_conv(16'h1234, 0, 0, 1);
    // R9 chained conversion of the inverted sample
    run_conv(~16'h1234, 0, 0, 0);

    for (int i = 0; i < 40; i++)
      run_conv(N'($urandom), 0, (i % 3) == 0, 0);

    // R1 reset mid-conversion
    @(negedge clk);
    vin = 16'h5555;
    conv_start = 1'b1;
    repeat (8) @(negedge clk);
    conv_start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle_chk("R1 reset mid conversion");
    chk(code == '0, "R1 code cleared", code, 0);
    last_code = '0;
    run_conv(16'h3C3C, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule